// File: doc/BRIEF.md
# Count-Based Single-Input-Change Codeword Generator

This block feeds a set of scan chains with low-transition stimulus built from Johnson-style codewords. It holds no register as long as the scan chain. A small fill counter records how many leading bits of the next codeword take the current fill polarity. While scan enable is low, that count is copied into a down-counter. While scan enable is high, the down-counter steps toward zero once per clock. A serial bit carries the fill polarity while the down-counter is non-zero and the opposite polarity once it has reached zero. The serial bit enters a shift register that is one stage per chain, and stage i drives the scan-in of chain i. Each chain therefore receives the same stream delayed by i clocks, so every chain sees a different codeword and each stream has at most one transition.

Each time scan enable falls, one window ends and the fill count advances. After SCAN_LEN windows the count wraps to zero and the polarity inverts. This gives the full cycle of 2·SCAN_LEN Johnson states: first runs of ones, then runs of zeros. The storage is two counters of about log2(SCAN_LEN) bits, a polarity bit, a registered copy of scan enable and NUM_CHAINS shift stages. Everything runs on one clock.

Top module: `sic_count_gen`

## Requirements
- R1: After reset, every scan-in output is 0, the fill count is 0 and the fill polarity is 1. The first window therefore produces a serial stream that is all 0.
- R2: On every clock with scanEn high, output bit 0 takes the current serial bit and output bit i takes the previous value of bit i-1, for i = 1 to NUM_CHAINS-1.
- R3: In a window that starts with fill count c, the serial bit equals the fill polarity for the first c shifts and the inverse polarity for every later shift. This includes shifts past SCAN_LEN, where the down-counter stays at zero.
- R4: Each falling edge of scanEn, seen at the first clock with scanEn low, raises the fill count by one. The count and the polarity change at no other time.
- R5: A falling edge that finds the fill count at SCAN_LEN-1 sets the count to 0 and inverts the polarity. Window w (counted from 0 after reset) thus has count w mod SCAN_LEN and polarity 1 when floor(w/SCAN_LEN) is even, otherwise 0.
- R6: While scanEn is low, all scan-in outputs hold their values.
- R7: When scanEn stays low for at least two clocks between windows, the next window uses the advanced fill count, even though the count changes in the same clock in which the down-counter reloads.
- R8: Over 2·SCAN_LEN consecutive windows of exactly SCAN_LEN shifts, the serial streams are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| scanEn | input | 1 | High during a shift window, low between windows |
| scanBits | output | NUM_CHAINS | Scan-in bit for each chain; bit i drives chain i |

## Verification
Two actions coincide in the first low clock after a window. The fill count steps (and may wrap and invert the polarity), and in the same clock the down-counter reloads from the value the count had before the step. The bench provokes this by keeping the gap between windows at the minimum of two low clocks and by making windows cross the wrap point in both polarities. It judges the result by comparing every shift of the following window with a model built from the window index alone. Windows shorter and longer than SCAN_LEN also check that the down-counter stops at zero while shifting continues.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef struct packed {
    logic shift;      // advance the chain-feed register this clock
    logic serialBit;  // bit entering stage 0
  } ctrlStrobes_t;
endpackage

// File: rtl/sic_fill_ctrl.sv
module sic_fill_ctrl
  import sic_pkg::*;
#(
  parameter int SCAN_LEN = 64,
  parameter int CNT_W    = $clog2(SCAN_LEN)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanEn,
  output ctrlStrobes_t strobes
);
  localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(SCAN_LEN - 1);

  logic             scanEnD;
  logic             fillPol;
  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] downCnt;
  logic             windowEnd;

  assign windowEnd = scanEnD & ~scanEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanEnD <= 1'b0;
    else       scanEnD <= scanEn;
  end

  // fill count and polarity: advance once per window end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      fillPol <= 1'b1;
    end else if (windowEnd) begin
      if (fillCnt == LAST_FILL) begin
        fillCnt <= '0;
        fillPol <= ~fillPol;
      end else begin
        fillCnt <= fillCnt + 1'b1;
      end
    end
  end

  // down-counter: reload while idle, count to zero while shifting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                downCnt <= '0;
    else if (!scanEn)         downCnt <= fillCnt;
    else if (downCnt != '0)   downCnt <= downCnt - 1'b1;
  end

  always_comb begin
    strobes.shift     = scanEn;
    strobes.serialBit = (downCnt != '0) ? fillPol : ~fillPol;
  end

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && downCnt != '0) |=> downCnt == CNT_W'($past(downCnt) - 1'b1)); // R3
  AST_DOWN_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && downCnt == '0) |=> downCnt == '0); // R3
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (windowEnd && fillCnt != LAST_FILL) |=>
      (fillCnt == CNT_W'($past(fillCnt) + 1'b1)) && $stable(fillPol)); // R4
  AST_FILL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (windowEnd && fillCnt == LAST_FILL) |=> (fillCnt == '0) && (fillPol != $past(fillPol))); // R5
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !windowEnd |=> $stable(fillCnt) && $stable(fillPol)); // R4
endmodule

// File: rtl/sic_shift_dp.sv
module sic_shift_dp
  import sic_pkg::*;
#(
  parameter int NUM_CHAINS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_CHAINS-1:0] chainBits
);
  logic [NUM_CHAINS-1:0] stageQ;
  logic [NUM_CHAINS-1:0] stageD;

  assign stageD[0] = strobes.serialBit;

  for (genvar gi = 0; gi < NUM_CHAINS; gi++) begin : gStage
    if (gi > 0) begin : gLink
      assign stageD[gi] = stageQ[gi-1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              stageQ[gi] <= 1'b0;
      else if (strobes.shift) stageQ[gi] <= stageD[gi];
    end
  end

  assign chainBits = stageQ;

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(stageQ)); // R6
  AST_STAGE_LINK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> stageQ[NUM_CHAINS-1:1] == $past(stageQ[NUM_CHAINS-2:0])); // R2
  AST_STAGE_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> stageQ[0] == $past(strobes.serialBit)); // R2
endmodule

// File: rtl/sic_count_gen.sv
module sic_count_gen
  import sic_pkg::*;
#(
  parameter int NUM_CHAINS = 10,
  parameter int SCAN_LEN   = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  scanEn,
  output logic [NUM_CHAINS-1:0] scanBits
);
  localparam int CNT_W = (SCAN_LEN > 2) ? $clog2(SCAN_LEN) : 1;

  ctrlStrobes_t strobes;

  sic_fill_ctrl #(.SCAN_LEN(SCAN_LEN), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .strobes(strobes)
  );

  sic_shift_dp #(.NUM_CHAINS(NUM_CHAINS)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .chainBits(scanBits)
  );

  initial begin
    AST_PARAM_RANGE: assert (NUM_CHAINS >= 2 && SCAN_LEN >= 2); // R2
  end

  AST_RESET_ZERO: assert property (@(posedge clk) $rose(rstN) |-> scanBits == '0); // R1
endmodule

// File: tb/tb_sic_count_gen.sv
module tb_sic_count_gen;
  localparam int M = 10;
  localparam int L = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         scanEn = 1'b0;
  logic [M-1:0] scanBits;

  int checks = 0;
  int fails  = 0;
  int win    = 0;
  bit done   = 0;
  logic [M-1:0] expReg = '0;
  logic [L-1:0] streams [2*L];

  always #10 clk = ~clk;

  sic_count_gen #(.NUM_CHAINS(M), .SCAN_LEN(L)) dut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanBits(scanBits)
  );

  // serial bit expected at shift n of window w (R3, R5)
  function automatic logic expSerial(int w, int n);
    int  c   = w % L;
    logic pol = (((w / L) % 2) == 0);
    return (n < c) ? pol : ~pol;
  endfunction

  task automatic check(string req, logic [M-1:0] act, logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: window %0d actual %b expected %b", req, win, act, exp);
    end
  endtask

  task automatic runWindow(int len, int gap);
    logic [L-1:0] s = '0;
    @(negedge clk);
    scanEn = 1'b1;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      expReg = {expReg[M-2:0], expSerial(win, n)};
      check("R3 serial bit", {{(M-1){1'b0}}, scanBits[0]}, {{(M-1){1'b0}}, expReg[0]});
      check("R2 chain shift", scanBits, expReg);
      if (n < L) s[L-1-n] = scanBits[0];
    end
    if (win < 2*L) streams[win] = s;
    scanEn = 1'b0;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      check("R6 hold while idle", scanBits, expReg);
    end
    win++;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", scanBits, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outputs after release", scanBits, '0);
    // full Johnson cycle: minimum gaps stress R7, window 0 checks R1 polarity
    for (int w = 0; w < 2*L; w++) begin
      int gap = (w % 3 == 0) ? 2 : 2 + int'($urandom_range(2));
      runWindow(L, gap); // R4 R5 R7
    end
    // R8: streams of the full cycle are distinct
    for (int a = 0; a < 2*L; a++)
      for (int b = a + 1; b < 2*L; b++) begin
        checks++;
        if (streams[a] === streams[b]) begin
          fails++;
          $display("FAIL R8 windows %0d and %0d share stream actual %h expected distinct", a, b, streams[a]);
        end
      end
    // directed corners: shortest and overlong windows
    runWindow(1, 2);        // R3
    runWindow(L + 12, 2);   // R3 down-counter floor
    // random lengths and gaps, crossing wraps (R4 R5)
    for (int r = 0; r < 60; r++)
      runWindow(1 + int'($urandom_range(L + 7)), 2 + int'($urandom_range(3)));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule